// File: doc/BRIEF.md
# Crosspoint Routing Matrix Configuration Controller

This block holds the routing configuration of an 8-output by 8-input video crosspoint. Every output gets a 3-bit input select and an enable bit. Configuration enters a first storage rank through a write strobe. A mode pin chooses how it enters: bit by bit over a serial line, or as a 4-bit command aimed at one output by a 3-bit address. In serial mode the bit that leaves the end of the chain appears on a cascade output, so several controllers can share one serial line.

A second rank holds the values that actually drive the per-output select decoders. Data moves from the first rank to the second in one of two ways, chosen by a pin: on a rising edge of a latch strobe, or continuously while the latch strobe is low. Some parallel commands also force this transfer. Because of the two ranks, a whole new routing pattern can be prepared and then switched in at one instant.

All strobes are sampled in one system clock domain. Rising edges are found by comparing each strobe with its value in the previous cycle.

Top module: `xpt_ctrl`

## Requirements
- R1: While reset is asserted, both ranks are cleared, so every output is disabled with select 0 and the cascade output is 0.
- R2: In parallel mode (`ser_mode_i`=0), a write-strobe rising edge with command 0 to 7 stores enable=1 and select=command into the first-rank entry of the output named by `addr_i`.
- R3: In parallel mode, command 8 clears the enable of the addressed output. Its select field and all other outputs are left unchanged.
- R4: In serial mode (`ser_mode_i`=1), each write-strobe rising edge shifts `cfg_d_i[0]` into a 32-bit first-rank chain. Output e occupies chain bits [4e+3:4e] as {enable, select[2:0]}. The first bit shifted in ends up at bit 31, so the bits are sent output 7 first, enable first and select MSB next.
- R5: The cascade output `ser_out_o` always shows chain bit 31, the bit that the next shift pushes out.
- R6: With `edge_mode_i`=1, the second rank copies the first rank on the cycle a latch rising edge is seen. Apart from the forced transfers of R8 and R9, it holds otherwise.
- R7: With `edge_mode_i`=0, the second rank follows the first rank with a one-cycle lag while `latch_i` is low. It holds while `latch_i` is high.
- R8: Parallel commands 11 to 14 leave the first rank unchanged and copy it into the second rank, whatever the latch strobe is doing.
- R9: Parallel command 15 copies the first rank into the second only if `latch_i` is high when the command executes. If `latch_i` is low it has no effect.
- R10: Parallel commands 9 and 10 change neither rank.
- R11: A write strobe held high for several cycles acts exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_mode_i | input | 1 | 1 = serial loading, 0 = parallel loading |
| edge_mode_i | input | 1 | 1 = second rank loads on latch rising edge, 0 = transparent while latch low |
| wr_i | input | 1 | Write strobe, acts on rising edge |
| latch_i | input | 1 | Second-rank latch strobe |
| cfg_d_i | input | 4 | Parallel command; bit 0 is the serial data input in serial mode |
| addr_i | input | 3 | Output addressed by a parallel command |
| en_o | output | 8 | Per-output enable from the second rank |
| sel_o | output | 24 | Per-output 3-bit input select, output e at bits [3e+2:3e] |
| ser_out_o | output | 1 | Cascade serial output (chain bit 31) |

## Verification
The bench writes every command 0 to 7 to every address. A design that decoded the address wrongly, or that disturbed neighbouring entries, shows up as a mismatch on some other output. It prepares pending first-rank data and then checks that the outputs stay put under a held latch, command 9, command 10 and command 15 with the latch low. A design that transferred too eagerly would expose the pending data early. A design that failed to transfer on a latch edge, on commands 11 to 14, or on command 15 with the latch high would show stale routing. The serial pass checks the cascade bit after every one of 32 shifts and then checks the decoded outputs. This catches a reversed chain order or an off-by-one position. A strobe held high for five cycles must shift only once.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [2:0] {
    OP_SELECT,
    OP_DISABLE,
    OP_NOP,
    OP_FORCE,
    OP_SOFT
  } op_e;

  // Classify a parallel command: the low 2**sel_w codes pick an input,
  // the next code disables, the top code is the conditional latch and the
  // four codes beneath it force a transfer.
  function automatic op_e decode_op(input int unsigned code, input int unsigned sel_w);
    int unsigned lim;
    op_e         op;
    lim = (32'd1 << (sel_w + 1)) - 1;
    if (code < (32'd1 << sel_w))       op = OP_SELECT;
    else if (code == (32'd1 << sel_w)) op = OP_DISABLE;
    else if (code == lim)              op = OP_SOFT;
    else if (code >= lim - 4)          op = OP_FORCE;
    else                               op = OP_NOP;
    return op;
  endfunction

  function automatic int unsigned chain_len(input int unsigned n_out, input int unsigned sel_w);
    return n_out * (sel_w + 1);
  endfunction

endpackage

// File: rtl/xpt_rise.sv
module xpt_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/xpt_rank1.sv
module xpt_rank1 import xpt_pkg::*; #(
  parameter int  N_OUT = 8,
  parameter int  SEL_W = 3,
  localparam int EW    = SEL_W + 1,
  localparam int CW    = SEL_W + 1,
  localparam int AW    = $clog2(N_OUT),
  localparam int CL    = N_OUT * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise_i,
  input  logic          ser_mode_i,
  input  op_e           op_i,
  input  logic [CW-1:0] code_i,
  input  logic [AW-1:0] addr_i,
  output logic [CL-1:0] chain_o
);
  logic [CL-1:0] chain_q;
  logic [CL-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (wr_rise_i) begin
      if (ser_mode_i) begin
        chain_d = {chain_q[CL-2:0], code_i[0]};
      end else begin
        for (int e = 0; e < N_OUT; e++) begin
          if (addr_i == AW'(e)) begin
            if (op_i == OP_SELECT)
              chain_d[e*EW +: EW] = {1'b1, code_i[SEL_W-1:0]};
            else if (op_i == OP_DISABLE)
              chain_d[e*EW + SEL_W] = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign chain_o = chain_q;
endmodule

// File: rtl/xpt_rank2.sv
module xpt_rank2 #(
  parameter int CL = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_mode_i,
  input  logic          latch_i,
  input  logic          latch_rise_i,
  input  logic          force_i,
  input  logic          soft_i,
  input  logic [CL-1:0] chain_i,
  output logic [CL-1:0] hold_o,
  output logic          xfer_o
);
  logic [CL-1:0] hold_q;
  logic          strobe_xfer;

  assign strobe_xfer = edge_mode_i ? latch_rise_i : ~latch_i;
  assign xfer_o      = strobe_xfer | force_i | (soft_i & latch_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (xfer_o) hold_q <= chain_i;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl import xpt_pkg::*; #(
  parameter int  N_OUT = 8,
  parameter int  SEL_W = 3,
  localparam int AW    = $clog2(N_OUT),
  localparam int CW    = SEL_W + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ser_mode_i,
  input  logic                   edge_mode_i,
  input  logic                   wr_i,
  input  logic                   latch_i,
  input  logic [CW-1:0]          cfg_d_i,
  input  logic [AW-1:0]          addr_i,
  output logic [N_OUT-1:0]       en_o,
  output logic [N_OUT*SEL_W-1:0] sel_o,
  output logic                   ser_out_o
);
  localparam int EW = SEL_W + 1;
  localparam int CL = chain_len(N_OUT, SEL_W);

  logic [1:0]    rise;
  logic          wr_rise;
  logic          latch_rise;
  op_e           op;
  logic          force_xfer;
  logic          soft_xfer;
  logic          xfer;
  logic [CL-1:0] chain_q;
  logic [CL-1:0] hold_q;

  xpt_rise #(.W(2)) u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  ({latch_i, wr_i}),
    .rise_o (rise)
  );
  assign wr_rise    = rise[0];
  assign latch_rise = rise[1];

  always_comb op = decode_op(32'(cfg_d_i), SEL_W);

  assign force_xfer = wr_rise & ~ser_mode_i & (op == OP_FORCE);
  assign soft_xfer  = wr_rise & ~ser_mode_i & (op == OP_SOFT);

  xpt_rank1 #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_rank1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_rise_i  (wr_rise),
    .ser_mode_i (ser_mode_i),
    .op_i       (op),
    .code_i     (cfg_d_i),
    .addr_i     (addr_i),
    .chain_o    (chain_q)
  );

  xpt_rank2 #(.CL(CL)) u_rank2 (
    .clk          (clk),
    .rst_n        (rst_n),
    .edge_mode_i  (edge_mode_i),
    .latch_i      (latch_i),
    .latch_rise_i (latch_rise),
    .force_i      (force_xfer),
    .soft_i       (soft_xfer),
    .chain_i      (chain_q),
    .hold_o       (hold_q),
    .xfer_o       (xfer)
  );

  for (genvar e = 0; e < N_OUT; e++) begin : g_out
    assign en_o[e]                 = hold_q[e*EW + SEL_W];
    assign sel_o[e*SEL_W +: SEL_W] = hold_q[e*EW +: SEL_W];
  end

  assign ser_out_o = chain_q[CL-1];
endmodule

// File: rtl/xpt_ctrl_chk.sv
module xpt_ctrl_chk #(
  parameter int  N_OUT = 8,
  parameter int  SEL_W = 3,
  localparam int CW    = SEL_W + 1,
  localparam int CL    = N_OUT * CW,
  localparam int TOP   = (1 << CW) - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_mode_i,
  input logic             edge_mode_i,
  input logic             latch_i,
  input logic             wr_rise,
  input logic             latch_rise,
  input logic             xfer,
  input logic [CW-1:0]    cfg_d_i,
  input logic [CL-1:0]    chain_q,
  input logic [CL-1:0]    hold_q,
  input logic [N_OUT-1:0] en_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (rst_n || (chain_q == '0 && hold_q == '0 && en_o == '0))); // R1

  AST_SERIAL_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    ser_mode_i && wr_rise |=> chain_q == {$past(chain_q[CL-2:0]), $past(cfg_d_i[0])}); // R4

  AST_HOLD_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(hold_q)); // R6

  AST_EDGE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode_i && latch_rise |=> hold_q == $past(chain_q)); // R6

  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode_i && !latch_i |=> hold_q == $past(chain_q)); // R7

  AST_FORCE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise && !ser_mode_i && cfg_d_i >= CW'(TOP - 4) && cfg_d_i < CW'(TOP)
    |=> hold_q == $past(chain_q) && $stable(chain_q)); // R8

  AST_SOFT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise && !ser_mode_i && cfg_d_i == CW'(TOP) && latch_i |=> hold_q == $past(chain_q)); // R9

  AST_NOP_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise && !ser_mode_i && cfg_d_i > CW'(1 << SEL_W) && cfg_d_i < CW'(TOP - 4)
    |=> $stable(chain_q)); // R10
endmodule

bind xpt_ctrl xpt_ctrl_chk #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/xpt_ctrl_tb_top.sv
module xpt_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_mode = 1'b0;
  logic        edge_mode = 1'b0;
  logic        wr = 1'b0;
  logic        latch = 1'b0;
  logic [3:0]  cfg_d = '0;
  logic [2:0]  addr = '0;
  logic [7:0]  en_o;
  logic [23:0] sel_o;
  logic        ser_out;

  int ncheck = 0;
  int nfail  = 0;
  bit done   = 1'b0;

  logic [3:0]  m1 [8];
  logic [3:0]  m2 [8];
  logic [31:0] flat_m;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xpt_ctrl dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_mode_i  (ser_mode),
    .edge_mode_i (edge_mode),
    .wr_i        (wr),
    .latch_i     (latch),
    .cfg_d_i     (cfg_d),
    .addr_i      (addr),
    .en_o        (en_o),
    .sel_o       (sel_o),
    .ser_out_o   (ser_out)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [31:0] pack_m1();
    logic [31:0] f;
    for (int e = 0; e < 8; e++) f[e*4 +: 4] = m1[e];
    return f;
  endfunction

  task automatic unpack_m1(input logic [31:0] f);
    for (int e = 0; e < 8; e++) m1[e] = f[e*4 +: 4];
  endtask

  task automatic check_outs(input string tag);
    logic [7:0]  ee;
    logic [23:0] es;
    for (int e = 0; e < 8; e++) begin
      ee[e]       = m2[e][3];
      es[e*3 +: 3] = m2[e][2:0];
    end
    ncheck++;
    if (en_o !== ee || sel_o !== es) begin
      nfail++;
      $display("FAIL %s: en=%h sel=%h expected en=%h sel=%h", tag, en_o, sel_o, ee, es);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    ncheck++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // Parallel command plus model update from the requirements.
  task automatic par_write(input int code, input int a);
    cfg_d = 4'(code);
    addr  = 3'(a);
    wr    = 1'b1;
    tick();
    wr = 1'b0;
    tick();
    tick();
    if (code < 8)                    m1[a] = {1'b1, 3'(code)};
    else if (code == 8)              m1[a][3] = 1'b0;
    else if (code >= 11 && code <= 14) m2 = m1;
    else if (code == 15 && latch)    m2 = m1;
    if (!edge_mode && !latch) m2 = m1;
  endtask

  task automatic latch_pulse();
    latch = 1'b1;
    tick();
    latch = 1'b0;
    tick();
    tick();
    m2 = m1;
  endtask

  task automatic ser_shift(input logic b);
    cfg_d = {3'b101, b};
    wr    = 1'b1;
    tick();
    wr = 1'b0;
    tick();
    flat_m = {flat_m[30:0], b};
    unpack_m1(flat_m);
    if (!edge_mode && !latch) m2 = m1;
  endtask

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncheck, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] target;
    for (int e = 0; e < 8; e++) begin m1[e] = '0; m2[e] = '0; end

    // R1 reset state
    repeat (3) tick();
    check_outs("R1 during reset");
    check_bit("R1 ser_out in reset", ser_out, 1'b0);
    rst_n = 1'b1;
    tick();
    check_outs("R1 after reset");

    // R2 sweep of every address and every select code, level mode, latch low
    for (int a = 0; a < 8; a++) begin
      for (int c = 0; c < 8; c++) begin
        par_write(c, a);
        check_outs($sformatf("R2 addr %0d code %0d", a, c));
      end
    end
    for (int a = 0; a < 8; a++) par_write((a + 3) % 8, a);
    check_outs("R2 final pattern");

    // R3 disable keeps select and neighbours
    par_write(8, 2);
    check_outs("R3 disable out2");
    par_write(8, 5);
    check_outs("R3 disable out5");

    // R7 level mode: hold while latch high, follow when low
    latch = 1'b1;
    tick();
    par_write(1, 0);
    check_outs("R7 held while latch high");
    latch = 1'b0;
    tick();
    tick();
    m2 = m1;
    check_outs("R7 follows after latch low");

    // R6 edge mode
    edge_mode = 1'b1;
    tick();
    par_write(6, 0);
    check_outs("R6 no transfer without latch edge");
    latch_pulse();
    check_outs("R6 transfer on latch edge");

    // R8 forced transfer codes, latch low in edge mode
    for (int c = 11; c <= 14; c++) begin
      par_write(c - 10, c - 8);
      check_outs($sformatf("R8 pending before code %0d", c));
      par_write(c, 0);
      check_outs($sformatf("R8 forced by code %0d", c));
    end

    // R9 soft latch
    par_write(7, 1);
    par_write(15, 1);
    check_outs("R9 code 15 with latch low does nothing");
    latch = 1'b1;
    tick();
    tick();
    m2 = m1;
    check_outs("R6 rise while entering R9 test");
    par_write(4, 6);
    check_outs("R9 pending while latch held high");
    par_write(15, 6);
    check_outs("R9 code 15 with latch high transfers");
    latch = 1'b0;
    tick();

    // R10 codes 9 and 10 change nothing
    par_write(0, 7);
    par_write(9, 7);
    check_outs("R10 code 9 no transfer");
    par_write(10, 3);
    check_outs("R10 code 10 no transfer");
    latch_pulse();
    check_outs("R10 first rank untouched by 9 and 10");

    // R4 / R5 serial chain, level mode with latch held high
    edge_mode = 1'b0;
    latch     = 1'b1;
    ser_mode  = 1'b1;
    tick();
    flat_m = pack_m1();
    check_bit("R5 ser_out before shifting", ser_out, flat_m[31]);
    for (int e = 0; e < 8; e++)
      target[e*4 +: 4] = {1'(e % 3 != 0), 3'((5 * e + 2) % 8)};
    for (int i = 31; i >= 0; i--) begin
      ser_shift(target[i]);
      check_bit($sformatf("R5 ser_out after shift of bit %0d", i), ser_out, flat_m[31]);
    end
    check_outs("R7 serial data held while latch high");
    latch = 1'b0;
    tick();
    tick();
    m2 = m1;
    check_outs("R4 serial chain decoded");

    // R11 held strobe shifts once
    cfg_d = 4'b0001;
    wr    = 1'b1;
    repeat (5) tick();
    wr = 1'b0;
    tick();
    tick();
    flat_m = {flat_m[30:0], 1'b1};
    unpack_m1(flat_m);
    m2 = m1;
    check_outs("R11 held write strobe acts once");
    check_bit("R11 ser_out after single shift", ser_out, flat_m[31]);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncheck, nfail);
    $finish;
  end
endmodule